// File: doc/BRIEF.md
# Cache Line Burst Fill Controller

This block completes a four-slot cache line once a single-longword miss fill has put one 32-bit word into the line. When `fill_req` is pulsed, it checks whether a burst is allowed. If it is, the block records the line's base address and reads the three missing longwords from a 32-bit memory port, one at a time. Each good response is passed to the line storage as a slot write, and that write also sets the slot's valid bit.

The fill starts at the slot just after the one already valid and wraps around within the 16-byte line. A bus error on any beat ends the fill at once and raises no exception. Slots written before the error stay valid, and the remaining slots stay invalid. The same controller serves an instruction cache and a data cache. The line valid bits and the line data live outside this block.

The controller has three states. In IDLE it waits for a qualified `fill_req`. Qualified means the burst input is high, control bits 0 (cache on) and 4 (burst on) are both set, the region is fast 32-bit memory, and exactly one valid bit is set; the controller then moves to ISSUE. ISSUE holds `mem_req` until `mem_ready` is high, then moves to WAIT. WAIT waits for a response. A good response writes the slot and moves back to ISSUE, or to IDLE after the third beat. An error response moves to IDLE and writes nothing. A synchronous reset forces IDLE from any state.

Top module: `line_burst_fill`

## Requirements
- R1: A fill starts only when `fill_req`, `burst_en`, `ctrl[0]`, `ctrl[4]` and `fast_region` are all high in the same cycle and `line_valid` has exactly one bit set. Otherwise no memory read is issued.
- R2: `busy` rises in the cycle after an accepted `fill_req` and stays high until the last response or an error response has been taken.
- R3: The start slot is the lowest-indexed valid slot s. Reads go to slots (s+1) mod 4, (s+2) mod 4 and (s+3) mod 4, in that order.
- R4: Each read address is `{phys_addr[31:4], slot, 2'b00}`, using `phys_addr` as captured when the fill was accepted. Later changes to `phys_addr` have no effect on the fill.
- R5: A good response (`mem_rsp_valid` high, `mem_rsp_err` low) in WAIT raises `wr_en` in the same cycle, with `wr_slot` equal to the slot being read and `wr_data` equal to `mem_rsp_data`.
- R6: An error response ends the fill. It produces no write and no further reads, and `busy` is low in the next cycle. Slots written before the error stay valid.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_req` and `mem_addr` hold their values. Only one read is outstanding at a time.
- R8: A `fill_req` that arrives while `busy` is high has no effect.
- R9: A synchronous reset returns the controller to IDLE, with `busy`, `mem_req` and `wr_en` low in the next cycle. The line valid bits are not touched.
- R10: A fill with no bus error issues exactly three reads and produces three writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_req | input | 1 | Pulse requesting a burst check after the first miss fill |
| burst_en | input | 1 | Global burst permission for this cache |
| ctrl | input | 8 | Control word; bit 0 = cache on, bit 4 = burst on |
| phys_addr | input | 32 | Translated physical address of the miss |
| fast_region | input | 1 | Address lies in 32-bit fast local memory |
| line_valid | input | 4 | Valid bits of the line's four slots |
| busy | output | 1 | Fill in progress |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 32 | Read address |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |
| mem_rsp_err | input | 1 | Read response is a bus error |
| wr_en | output | 1 | Write a slot and set its valid bit |
| wr_slot | output | 2 | Slot index to write |
| wr_data | output | 32 | Data to write |

## Verification
`busy` and the first `mem_req` appear one cycle after the edge that accepts `fill_req`. Each request is accepted on the edge where `mem_ready` is high. `wr_en` is a combinational echo of a response, so it is visible in the same cycle as `mem_rsp_valid`. After an error response or the last response, `busy` is low in the next cycle.

The bench drives every input just after the falling edge and samples a short delay after it. The memory model records a request only when `mem_req` and `mem_ready` are both high, and it answers in the cycle after acceptance. Because of that, addresses, writes and the `busy` level are all compared in the cycle in which the rules above make them due.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } lbf_state_e;
endpackage

// File: rtl/lbf_qualify.sv
module lbf_qualify #(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]  line_valid,
    output logic              one_valid,
    output logic [SLOT_W-1:0] first_slot
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones       = '0;
        first_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (line_valid[i]) begin
                ones       = ones + CNT_W'(1);
                first_slot = SLOT_W'(i);
            end
        end
        one_valid = (ones == CNT_W'(1));
    end
endmodule

// File: rtl/lbf_addr.sv
module lbf_addr #(
    parameter int ADDR_W   = 32,
    parameter int SLOT_W   = 2,
    parameter int BYTE_W   = 2,
    parameter int LINE_LSB = SLOT_W + BYTE_W
) (
    input  logic [ADDR_W-1:LINE_LSB] base,
    input  logic [SLOT_W-1:0]        slot,
    output logic [ADDR_W-1:0]        addr
);
    assign addr = {base, slot, {BYTE_W{1'b0}}};
endmodule

// File: rtl/line_burst_fill.sv
module line_burst_fill
    import lbf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SLOTS     = 4,
    parameter int CTRL_W    = 8,
    parameter int EN_BIT    = 0,
    parameter int BURST_BIT = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      fill_req,
    input  logic                      burst_en,
    input  logic [CTRL_W-1:0]         ctrl,
    input  logic [ADDR_W-1:0]         phys_addr,
    input  logic                      fast_region,
    input  logic [SLOTS-1:0]          line_valid,
    output logic                      busy,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic                      mem_ready,
    input  logic                      mem_rsp_valid,
    input  logic [DATA_W-1:0]         mem_rsp_data,
    input  logic                      mem_rsp_err,
    output logic                      wr_en,
    output logic [$clog2(SLOTS)-1:0]  wr_slot,
    output logic [DATA_W-1:0]         wr_data
);
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int BYTE_W   = $clog2(DATA_W / 8);
    localparam int LINE_LSB = SLOT_W + BYTE_W;
    localparam int BEATS    = SLOTS - 1;
    localparam int BEAT_W   = $clog2(SLOTS);

    lbf_state_e                state_q;
    logic [ADDR_W-1:LINE_LSB]  base_q;
    logic [SLOT_W-1:0]         slot_q;
    logic [BEAT_W-1:0]         beat_q;
    logic                      one_valid;
    logic [SLOT_W-1:0]         first_slot;
    logic                      start_ok;
    logic                      last_beat;
    logic [LINE_LSB-1:0]       unused_low;

    assign unused_low = phys_addr[LINE_LSB-1:0];

    lbf_qualify #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_qual (
        .line_valid (line_valid),
        .one_valid  (one_valid),
        .first_slot (first_slot)
    );

    lbf_addr #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .BYTE_W(BYTE_W), .LINE_LSB(LINE_LSB)) u_addr (
        .base (base_q),
        .slot (slot_q),
        .addr (mem_addr)
    );

    assign start_ok  = fill_req && burst_en && ctrl[EN_BIT] && ctrl[BURST_BIT]
                       && fast_region && one_valid;
    assign last_beat = (beat_q == BEAT_W'(BEATS - 1));

    // State register and burst bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            slot_q  <= '0;
            beat_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        state_q <= ST_ISSUE;
                        base_q  <= phys_addr[ADDR_W-1:LINE_LSB];
                        slot_q  <= first_slot + SLOT_W'(1);
                        beat_q  <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (mem_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err || last_beat) begin
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_ISSUE;
                            slot_q  <= slot_q + SLOT_W'(1);
                            beat_q  <= beat_q + BEAT_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = 1'b0;
        mem_req = 1'b0;
        wr_en   = 1'b0;
        wr_slot = slot_q;
        wr_data = mem_rsp_data;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin
                busy    = 1'b1;
                mem_req = 1'b1;
            end
            ST_WAIT: begin
                busy  = 1'b1;
                wr_en = mem_rsp_valid && !mem_rsp_err;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/lbf_checker.sv
module lbf_checker #(
    parameter int ADDR_W   = 32,
    parameter int LINE_LSB = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rsp_valid,
    input logic              mem_rsp_err,
    input logic              wr_en
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    assert_write_in_burst_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (busy && mem_rsp_valid && !mem_req));

    assert_err_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (armed && busy && !mem_req && mem_rsp_valid && mem_rsp_err) |=> !busy);

    assert_base_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:LINE_LSB]));

    assert_start_issues_R2: assert property (@(posedge clk) disable iff (rst)
        (armed && $rose(busy)) |-> mem_req);

    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (!busy && !mem_req && !wr_en));
endmodule

bind line_burst_fill lbf_checker #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .wr_en         (wr_en)
);

// File: tb/sim_line_burst_fill.sv
`timescale 1ns/1ps
module sim_line_burst_fill;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fill_req = 1'b0;
    logic        burst_en = 1'b0;
    logic [7:0]  ctrl = 8'h00;
    logic [31:0] phys_addr = '0;
    logic        fast_region = 1'b0;
    logic [3:0]  line_valid;
    logic        busy, mem_req, wr_en;
    logic [31:0] mem_addr, wr_data;
    logic [1:0]  wr_slot;
    logic        mem_ready = 1'b1;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side line model
    logic [3:0]  vmod = 4'b0000;
    logic [31:0] dmod [4];
    logic [31:0] seen_addr [8];
    int          n_addr = 0;
    int          n_rsp  = 0;
    int          err_at = 3;
    bit          pending = 0;
    logic [31:0] pend_addr = '0;

    assign line_valid = vmod;

    always #10 clk = ~clk;

    line_burst_fill u0 (
        .clk(clk), .rst(rst), .fill_req(fill_req), .burst_en(burst_en), .ctrl(ctrl),
        .phys_addr(phys_addr), .fast_region(fast_region), .line_valid(line_valid),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data)
    );

    function automatic logic [31:0] data_of(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A00_00C3;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder and line writer, works at falling edges
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = pending;
            mem_rsp_err   = pending && (n_rsp == err_at);
            mem_rsp_data  = data_of(pend_addr);
            if (pending) n_rsp++;
            pending = 0;
            #1;
            if (wr_en) begin
                vmod[wr_slot] = 1'b1;
                dmod[wr_slot] = wr_data;
            end
            if (mem_req && mem_ready) begin
                if (n_addr < 8) seen_addr[n_addr] = mem_addr;
                n_addr++;
                pending   = 1;
                pend_addr = mem_addr;
            end
        end
    end

    typedef struct packed {
        logic [3:0]  v;
        logic [7:0]  c;
        logic        ben;
        logic        fast;
        logic [31:0] addr;
        logic [1:0]  eb;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{4'b0001, 8'h11, 1'b1, 1'b1, 32'h0000_1230, 2'd3},
        '{4'b0010, 8'h11, 1'b1, 1'b1, 32'h0040_2244, 2'd3},
        '{4'b0100, 8'hFF, 1'b1, 1'b1, 32'h8000_0FF8, 2'd3},
        '{4'b1000, 8'h31, 1'b1, 1'b1, 32'h1234_567C, 2'd3},
        '{4'b0001, 8'h11, 1'b1, 1'b0, 32'h0000_5000, 2'd3},
        '{4'b0010, 8'h01, 1'b1, 1'b1, 32'h0000_6004, 2'd3},
        '{4'b0010, 8'h10, 1'b1, 1'b1, 32'h0000_7004, 2'd3},
        '{4'b0100, 8'h11, 1'b0, 1'b1, 32'h0000_8008, 2'd3},
        '{4'b0101, 8'h11, 1'b1, 1'b1, 32'h0000_9000, 2'd3},
        '{4'b0000, 8'h11, 1'b1, 1'b1, 32'h0000_A000, 2'd3},
        '{4'b0010, 8'h11, 1'b1, 1'b1, 32'hCAFE_0014, 2'd0},
        '{4'b1000, 8'h11, 1'b1, 1'b1, 32'hCAFE_002C, 2'd1},
        '{4'b0001, 8'h11, 1'b1, 1'b1, 32'hCAFE_0030, 2'd2}
    };

    task automatic clear_model(input logic [3:0] v, input int eb);
        vmod = v;
        for (int k = 0; k < 4; k++) dmod[k] = '0;
        n_addr = 0;
        n_rsp  = 0;
        err_at = eb;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #2;
            if (!busy) break;
        end
        @(negedge clk); #2;
    endtask

    initial begin : wd
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(!busy && !mem_req && !wr_en, "R9 reset idle", {busy, mem_req, wr_en}, 0);
        @(negedge clk); rst = 0;

        for (int i = 0; i < NV; i++) begin
            vec_t t;
            bit go;
            int s, nbeat, nwr;
            logic [3:0] expv;
            t = VEC[i];
            clear_model(t.v, int'(t.eb));
            go = t.ben && t.c[0] && t.c[4] && t.fast && ($countones(t.v) == 1);
            s = 0;
            for (int k = 3; k >= 0; k--) if (t.v[k]) s = k;
            nbeat = !go ? 0 : (t.eb == 2'd3 ? 3 : int'(t.eb) + 1);
            nwr   = !go ? 0 : (t.eb == 2'd3 ? 3 : int'(t.eb));
            @(negedge clk);
            burst_en = t.ben; ctrl = t.c; fast_region = t.fast; phys_addr = t.addr;
            fill_req = 1;
            @(negedge clk);
            fill_req = 0;
            #2;
            check(busy == go, "R1/R2 busy after request", {31'd0, busy}, {31'd0, go});
            wait_idle();
            check(n_addr == nbeat, "R1/R6/R10 read count", n_addr, nbeat);
            for (int k = 0; k < nbeat && k < n_addr; k++) begin
                logic [31:0] ea;
                ea = {t.addr[31:4], 2'(s + 1 + k), 2'b00};
                check(seen_addr[k] == ea, "R3/R4 read address", seen_addr[k], ea);
            end
            expv = t.v;
            for (int k = 0; k < nwr; k++) expv[2'(s + 1 + k)] = 1'b1;
            check(vmod == expv, "R5/R6 line valid", {28'd0, vmod}, {28'd0, expv});
            for (int k = 0; k < nwr; k++) begin
                logic [31:0] ea;
                ea = {t.addr[31:4], 2'(s + 1 + k), 2'b00};
                check(dmod[2'(s + 1 + k)] == data_of(ea), "R5 slot data", dmod[2'(s + 1 + k)], data_of(ea));
            end
        end

        // R7 R8 R4: stalled handshake, new request and address change while busy
        clear_model(4'b0100, 3);
        @(negedge clk);
        burst_en = 1; ctrl = 8'h11; fast_region = 1; phys_addr = 32'h0ABC_DE48;
        mem_ready = 0; fill_req = 1;
        @(negedge clk); fill_req = 0;
        repeat (3) @(negedge clk);
        #2;
        check(mem_req && busy, "R7 request held while stalled", {mem_req, busy}, 2'b11);
        check(mem_addr == 32'h0ABC_DE4C, "R7 address held while stalled", mem_addr, 32'h0ABC_DE4C);
        @(negedge clk);
        vmod = 4'b0001; phys_addr = 32'h1111_1110; fill_req = 1;
        @(negedge clk);
        fill_req = 0; vmod = 4'b0100;
        mem_ready = 1;
        wait_idle();
        check(n_addr == 3, "R8 no restart while busy", n_addr, 3);
        check(seen_addr[0] == 32'h0ABC_DE4C && seen_addr[1] == 32'h0ABC_DE40 &&
              seen_addr[2] == 32'h0ABC_DE44, "R4 captured base kept", seen_addr[1], 32'h0ABC_DE40);

        // R9: reset during a fill
        clear_model(4'b0001, 3);
        @(negedge clk);
        phys_addr = 32'h0000_2000; fill_req = 1;
        @(negedge clk); fill_req = 0;
        @(negedge clk);
        rst = 1;
        @(negedge clk); #2;
        check(!busy && !mem_req && !wr_en, "R9 reset mid fill", {busy, mem_req, wr_en}, 0);
        rst = 0;
        n_addr = 0;
        repeat (4) @(negedge clk);
        #2;
        check(n_addr == 0 && !busy, "R9 stays idle after reset", n_addr, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule